// File: doc/BRIEF.md
# Type 0 Configuration Header and Address Window Decoder

This block holds the sixteen dwords of a type 0 configuration header for a single-function device that sits on a point-to-point link. Software reaches it through a dword-wide port. The port takes a dword index, a write strobe, per-byte enables and write data. Read data follows the dword index combinationally. The header carries fixed identification values, a small command field, a capability-list status flag, three address windows, the capabilities pointer and the interrupt bytes. Every legacy field that has no meaning on a link reads as zero.

The same registers also steer incoming requests. A request presents a 40-bit address, a flag that says I/O or memory, and a valid strobe. One cycle later the block reports whether a window claimed the request and which one.

The block has three windows:
- An I/O window that compares address bits 24 down to its size.
- A 32-bit memory window that only claims addresses below 4 GB.
- A 64-bit memory window built from two adjacent dwords, of which only address bits 39:0 matter.

Every memory window is at least 64 bytes, so address bits 5:0 never take part in a memory match.

Top module: `cfg_hdr_decode`

## Requirements
- R1: Dword 0 (offset 00h) reads {DEVICE_ID, VENDOR_ID}. Dword 2 (08h) reads {CLASS_CODE, REV_ID}. Dword 3 (0Ch), which holds the header type byte, reads 0, so the header type is 0. Writes to dwords 0 and 2 have no effect.
- R2: The following offsets always read 0 and ignore writes:
  - cache line size and latency timer (0Ch)
  - CardBus pointer (28h)
  - unused BAR slots (20h, 24h)
  - subsystem (2Ch), expansion ROM (30h) and 38h
  - minimum grant and maximum latency bytes (3Eh, 3Fh)
- R3: In dword 1 (04h), bits 2:0 are writable command bits: bit 0 is the I/O decode enable, bit 1 the memory decode enable, bit 2 bus master. Bit 20 (status capability list) reads 1. All other bits read 0. Reset clears the command bits.
- R4: A write changes only the byte lanes whose byte enable bit is set. Byte enable bit n covers data bits 8n+7:8n.
- R5: The I/O BAR sits at dword 4 (10h). Bit 0 reads 1. Bits 24:IO_SIZE_LOG2 are writable. All other bits read 0. Writing all ones reads back the size mask.
- R6: An I/O request hits the I/O window (window code 1) when the I/O decode enable is set and req_addr[24:IO_SIZE_LOG2] equals the BAR's bits. Address bits 39:25 are ignored. I/O requests never match memory windows.
- R7: The 32-bit memory BAR sits at dword 5 (14h). Bits 3:0 read 0000, and bits 31:M32_SIZE_LOG2 are writable. A memory request hits it (code 2) only when req_addr[39:32] is zero and bits 31:M32_SIZE_LOG2 match.
- R8: The 64-bit memory BAR sits at dwords 6 and 7 (18h, 1Ch).
  - The low dword reads 0100 in bits 3:0 and has bits 31:M64_SIZE_LOG2 writable.
  - The high dword has bits 7:0 writable and reads 0 in bits 31:8.
  - A memory request hits it (code 3) when req_addr[39:M64_SIZE_LOG2] matches.
- R9: Memory hits require the memory decode enable. When both memory windows match, the 32-bit window wins.
- R10: req_hit and req_win reflect the request present at the previous clock edge. Both are 0 when that request was not valid, after reset, or on a miss. req_win is 0 exactly when req_hit is 0.
- R11: Dword 13 (34h) reads CAP_PTR in bits 7:0 and 0 elsewhere, and ignores writes.
- R12: In dword 15 (3Ch), bits 7:0 are a read/write scratch byte that resets to 0. Bits 15:8 read INT_PIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 4 | Dword index into the header |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| req_valid | input | 1 | Request present |
| req_is_io | input | 1 | 1 for I/O request, 0 for memory |
| req_addr | input | 40 | Request address |
| req_hit | output | 1 | A window claimed the last request |
| req_win | output | 2 | Window code: 0 none, 1 I/O, 2 mem32, 3 mem64 |

## Verification
The assertions relate a hit to the request and enable bits present one edge earlier, so they assume the request inputs are stable across each capturing edge. They also assume that a configuration write in the same cycle as a request is judged against the old BAR contents. The stimulus changes every input just after a rising edge and holds it for a whole cycle. It never issues a request while the same BAR is being written. The parameter sizes are assumed to stay in the range the header can hold: memory windows of at least 64 bytes, and an I/O window below bit 25.

// File: rtl/cfghdr_pkg.sv
package cfghdr_pkg;

    localparam int DW_COUNT = 16;

    localparam int DW_ID    = 0;
    localparam int DW_CMD   = 1;
    localparam int DW_CLASS = 2;
    localparam int DW_IOBAR = 4;
    localparam int DW_M32   = 5;
    localparam int DW_M64LO = 6;
    localparam int DW_M64HI = 7;
    localparam int DW_CAP   = 13;
    localparam int DW_INT   = 15;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_IO    = 2'd1,
        WIN_MEM32 = 2'd2,
        WIN_MEM64 = 2'd3
    } win_e;

    typedef struct packed {
        logic        valid;
        logic        is_io;
        logic [39:0] addr;
    } req_t;

    typedef struct packed {
        logic        io_en;
        logic        mem_en;
        logic [24:0] io_base;
        logic [31:0] m32_base;
        logic [39:0] m64_base;
    } win_cfg_t;

    function automatic logic [31:0] clear_below(input int n);
        logic [31:0] one;
        one = 32'd1;
        return ~((one << n) - one);
    endfunction

    // Writable bits of each header dword.
    function automatic logic [31:0] dw_wmask(input int idx, input int io_lg,
                                             input int m32_lg, input int m64_lg);
        case (idx)
            DW_CMD:   return 32'h0000_0007;
            DW_IOBAR: return clear_below(io_lg) & 32'h01FF_FFFF;
            DW_M32:   return clear_below(m32_lg);
            DW_M64LO: return clear_below(m64_lg);
            DW_M64HI: return 32'h0000_00FF;
            DW_INT:   return 32'h0000_00FF;
            default:  return 32'h0;
        endcase
    endfunction

    // Fixed bits of each header dword.
    function automatic logic [31:0] dw_const(input int idx, input logic [15:0] vid,
                                             input logic [15:0] did, input logic [23:0] cls,
                                             input logic [7:0] rev, input logic [7:0] cap,
                                             input logic [7:0] pin);
        case (idx)
            DW_ID:    return {did, vid};
            DW_CMD:   return 32'h0010_0000;
            DW_CLASS: return {cls, rev};
            DW_IOBAR: return 32'h0000_0001;
            DW_M64LO: return 32'h0000_0004;
            DW_CAP:   return {24'h0, cap};
            DW_INT:   return {16'h0, pin, 8'h0};
            default:  return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_dword_reg.sv
module cfg_dword_reg #(
    parameter logic [31:0] WMASK = 32'h0,
    parameter logic [31:0] RVAL  = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    logic unused_inputs;
    assign unused_inputs = ^{wdata, be};

    for (genvar b = 0; b < 4; b++) begin : g_lane
        localparam logic [7:0] LM = WMASK[8*b +: 8];
        if (LM != 8'h00) begin : g_store
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr && be[b]) begin
                    q <= wdata[8*b +: 8] & LM;
                end
            end
            assign rdata[8*b +: 8] = q | RVAL[8*b +: 8];
        end else begin : g_fixed
            assign rdata[8*b +: 8] = RVAL[8*b +: 8];
        end
    end
endmodule

// File: rtl/cfg_win_match.sv
module cfg_win_match
    import cfghdr_pkg::*;
#(
    parameter int IO_SIZE_LOG2  = 8,
    parameter int M32_SIZE_LOG2 = 12,
    parameter int M64_SIZE_LOG2 = 20
) (
    input  logic     clk,
    input  logic     rst,
    input  req_t     req,
    input  win_cfg_t wc,
    output logic     hit,
    output win_e     win
);
    logic io_m, m32_m, m64_m;
    win_e win_d;
    logic unused_fields;
    assign unused_fields = ^{req, wc};

    always_comb begin
        io_m  = req.is_io && wc.io_en &&
                (req.addr[24:IO_SIZE_LOG2] == wc.io_base[24:IO_SIZE_LOG2]);
        m32_m = !req.is_io && wc.mem_en && (req.addr[39:32] == 8'h00) &&
                (req.addr[31:M32_SIZE_LOG2] == wc.m32_base[31:M32_SIZE_LOG2]);
        m64_m = !req.is_io && wc.mem_en &&
                (req.addr[39:M64_SIZE_LOG2] == wc.m64_base[39:M64_SIZE_LOG2]);
        if (!req.valid)  win_d = WIN_NONE;
        else if (io_m)   win_d = WIN_IO;
        else if (m32_m)  win_d = WIN_MEM32;
        else if (m64_m)  win_d = WIN_MEM64;
        else             win_d = WIN_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit <= 1'b0;
            win <= WIN_NONE;
        end else begin
            hit <= req.valid && (io_m || m32_m || m64_m);
            win <= win_d;
        end
    end
endmodule

// File: rtl/cfg_hdr_decode.sv
module cfg_hdr_decode
    import cfghdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID     = 16'h3C4D,
    parameter logic [23:0] CLASS_CODE    = 24'h058000,
    parameter logic [7:0]  REV_ID        = 8'h01,
    parameter logic [7:0]  CAP_PTR       = 8'h40,
    parameter logic [7:0]  INT_PIN       = 8'h00,
    parameter int          IO_SIZE_LOG2  = 8,
    parameter int          M32_SIZE_LOG2 = 12,
    parameter int          M64_SIZE_LOG2 = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  cfg_addr,
    input  logic        cfg_wr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        req_valid,
    input  logic        req_is_io,
    input  logic [39:0] req_addr,
    output logic        req_hit,
    output logic [1:0]  req_win
);
    logic [31:0] dw_rd [DW_COUNT];
    logic        cmd_io_en;
    logic        cmd_mem_en;
    req_t        req;
    win_cfg_t    wc;
    win_e        win;

    for (genvar g = 0; g < DW_COUNT; g++) begin : g_dw
        localparam logic [31:0] WM = dw_wmask(g, IO_SIZE_LOG2, M32_SIZE_LOG2, M64_SIZE_LOG2);
        localparam logic [31:0] RV = dw_const(g, VENDOR_ID, DEVICE_ID, CLASS_CODE,
                                              REV_ID, CAP_PTR, INT_PIN);
        if (WM != 32'h0) begin : g_rw
            cfg_dword_reg #(.WMASK(WM), .RVAL(RV)) u_reg (
                .clk   (clk),
                .rst   (rst),
                .wr    (cfg_wr && (cfg_addr == 4'(g))),
                .be    (cfg_be),
                .wdata (cfg_wdata),
                .rdata (dw_rd[g])
            );
        end else begin : g_ro
            assign dw_rd[g] = RV;
        end
    end

    assign cfg_rdata  = dw_rd[cfg_addr];
    assign cmd_io_en  = dw_rd[DW_CMD][0];
    assign cmd_mem_en = dw_rd[DW_CMD][1];

    always_comb begin
        req.valid   = req_valid;
        req.is_io   = req_is_io;
        req.addr    = req_addr;
        wc.io_en    = cmd_io_en;
        wc.mem_en   = cmd_mem_en;
        wc.io_base  = dw_rd[DW_IOBAR][24:0];
        wc.m32_base = dw_rd[DW_M32];
        wc.m64_base = {dw_rd[DW_M64HI][7:0], dw_rd[DW_M64LO]};
    end

    cfg_win_match #(
        .IO_SIZE_LOG2  (IO_SIZE_LOG2),
        .M32_SIZE_LOG2 (M32_SIZE_LOG2),
        .M64_SIZE_LOG2 (M64_SIZE_LOG2)
    ) u_match (
        .clk (clk),
        .rst (rst),
        .req (req),
        .wc  (wc),
        .hit (req_hit),
        .win (win)
    );

    assign req_win = win;
endmodule

// File: rtl/cfg_hdr_checker.sv
module cfg_hdr_checker #(
    parameter logic [7:0] CAP_PTR       = 8'h40,
    parameter int         IO_SIZE_LOG2  = 8,
    parameter int         M32_SIZE_LOG2 = 12,
    parameter int         M64_SIZE_LOG2 = 20
) (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  cfg_addr,
    input logic [31:0] cfg_rdata,
    input logic        req_valid,
    input logic        req_is_io,
    input logic        req_hit,
    input logic [1:0]  req_win,
    input logic        io_en,
    input logic        mem_en
);
    initial begin
        p_sizes_r8: assert (M32_SIZE_LOG2 >= 6 && M32_SIZE_LOG2 <= 31 &&
                            M64_SIZE_LOG2 >= 6 && M64_SIZE_LOG2 <= 31 &&
                            IO_SIZE_LOG2 >= 2 && IO_SIZE_LOG2 <= 24);
    end

    p_hit_after_valid_r10: assert property (@(posedge clk) disable iff (rst)
        req_hit |-> $past(req_valid));

    p_win_code_r10: assert property (@(posedge clk) disable iff (rst)
        (req_win != 2'd0) == req_hit);

    p_io_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (req_hit && req_win == 2'd1) |-> ($past(io_en) && $past(req_is_io)));

    p_mem_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (req_hit && req_win[1]) |-> ($past(mem_en) && !$past(req_is_io)));

    p_legacy_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == 4'd3 || cfg_addr == 4'd10 || cfg_addr == 4'd11) |-> (cfg_rdata == 32'h0));

    p_cap_ptr_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == 4'd13) |-> (cfg_rdata == {24'h0, CAP_PTR}));
endmodule

bind cfg_hdr_decode cfg_hdr_checker #(
    .CAP_PTR       (CAP_PTR),
    .IO_SIZE_LOG2  (IO_SIZE_LOG2),
    .M32_SIZE_LOG2 (M32_SIZE_LOG2),
    .M64_SIZE_LOG2 (M64_SIZE_LOG2)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .req_valid (req_valid),
    .req_is_io (req_is_io),
    .req_hit   (req_hit),
    .req_win   (req_win),
    .io_en     (cmd_io_en),
    .mem_en    (cmd_mem_en)
);

// File: tb/sim_cfg_hdr_decode.sv
`timescale 1ns/1ps
module sim_cfg_hdr_decode;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_is_io = 1'b0;
    logic [39:0] req_addr = '0;
    logic        req_hit;
    logic [1:0]  req_win;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cfg_hdr_decode u0 (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_is_io(req_is_io), .req_addr(req_addr), .req_hit(req_hit), .req_win(req_win)
    );

    // Behavioural model of the header, written from the requirements.
    logic [31:0] mdw [16];
    logic        e_hit;
    logic [1:0]  e_win;

    function automatic logic [31:0] mwm(input int i);
        case (i)
            1: return 32'h0000_0007;
            4: return 32'h01FF_FF00;
            5: return 32'hFFFF_F000;
            6: return 32'hFFF0_0000;
            7: return 32'h0000_00FF;
            15: return 32'h0000_00FF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] mcv(input int i);
        case (i)
            0: return 32'h3C4D_1A2B;
            1: return 32'h0010_0000;
            2: return 32'h0580_0001;
            4: return 32'h0000_0001;
            6: return 32'h0000_0004;
            13: return 32'h0000_0040;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            0, 2: return "R1";
            1: return "R3";
            4: return "R5";
            5: return "R7";
            6, 7: return "R8";
            13: return "R11";
            15: return "R12";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) mdw[i] = 32'h0;
            e_hit = 1'b0;
            e_win = 2'd0;
        end else begin
            logic io_m, m32_m, m64_m;
            logic [31:0] bm;
            io_m  = req_is_io && mdw[1][0] && (req_addr[24:8] == mdw[4][24:8]);
            m32_m = !req_is_io && mdw[1][1] && (req_addr[39:32] == 8'h0) &&
                    (req_addr[31:12] == mdw[5][31:12]);
            m64_m = !req_is_io && mdw[1][1] &&
                    (req_addr[39:20] == {mdw[7][7:0], mdw[6][31:20]});
            e_hit = req_valid && (io_m || m32_m || m64_m);
            e_win = !req_valid ? 2'd0 : io_m ? 2'd1 : m32_m ? 2'd2 : m64_m ? 2'd3 : 2'd0;
            if (cfg_wr) begin
                bm = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}};
                mdw[cfg_addr] = ((mdw[cfg_addr] & ~bm) | (cfg_wdata & bm)) & mwm(int'(cfg_addr));
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(tag_of(int'(cfg_addr)), 64'(cfg_rdata), 64'(mdw[cfg_addr] | mcv(int'(cfg_addr))));
            chk("R10", 64'({req_hit, req_win}), 64'({e_hit, e_win}));
        end
    end

    task automatic cwrite(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
        @(posedge clk); #1;
        cfg_addr = a; cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic cread(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        cfg_addr = a;
        @(negedge clk);
        chk(tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic creq(input logic [39:0] a, input logic io, input logic h,
                        input logic [1:0] w, input string tag);
        @(posedge clk); #1;
        req_addr = a; req_is_io = io; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(tag, 64'({req_hit, req_win}), 64'({h, w}));
    endtask

    task automatic finish_run;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // Reset state
        cread(4'd1, 32'h0010_0000, "R3 reset");
        cread(4'd4, 32'h0000_0001, "R5 reset");
        cread(4'd6, 32'h0000_0004, "R8 reset");
        cread(4'd15, 32'h0000_0000, "R12 reset");
        @(negedge clk); chk("R10 reset", 64'({req_hit, req_win}), 64'h0);
        // Identification, read-only
        cwrite(4'd0, 32'hFFFF_FFFF, 4'hF);
        cwrite(4'd2, 32'h0, 4'hF);
        cread(4'd0, 32'h3C4D_1A2B, "R1 id");
        cread(4'd2, 32'h0580_0001, "R1 class");
        // Legacy and unused offsets
        for (int i = 0; i < 16; i++) begin
            if (i == 3 || i == 8 || i == 9 || i == 10 || i == 11 || i == 12 || i == 14) begin
                cwrite(4'(i), 32'hFFFF_FFFF, 4'hF);
                cread(4'(i), 32'h0, "R2 legacy");
            end
        end
        // Command
        cwrite(4'd1, 32'hFFFF_FFFF, 4'hF);
        cread(4'd1, 32'h0010_0007, "R3 cmd");
        // Sizing
        cwrite(4'd4, 32'hFFFF_FFFF, 4'hF);
        cread(4'd4, 32'h01FF_FF01, "R5 size");
        cwrite(4'd5, 32'hFFFF_FFFF, 4'hF);
        cread(4'd5, 32'hFFFF_F000, "R7 size");
        cwrite(4'd6, 32'hFFFF_FFFF, 4'hF);
        cread(4'd6, 32'hFFF0_0004, "R8 size lo");
        cwrite(4'd7, 32'hFFFF_FFFF, 4'hF);
        cread(4'd7, 32'h0000_00FF, "R8 size hi");
        // Byte enables
        cwrite(4'd5, 32'h1234_5678, 4'b0100);
        cread(4'd5, 32'hFF34_F000, "R4 lane2");
        cwrite(4'd15, 32'h0000_005A, 4'b1110);
        cread(4'd15, 32'h0000_0000, "R4 masked lane");
        // Program windows
        cwrite(4'd4, 32'h0000_1200, 4'hF);
        cread(4'd4, 32'h0000_1201, "R5 prog");
        cwrite(4'd5, 32'h8000_0000, 4'hF);
        cwrite(4'd6, 32'h0010_0000, 4'hF);
        cwrite(4'd7, 32'h0000_005A, 4'hF);
        cread(4'd6, 32'h0010_0004, "R8 prog");
        // Decode gated off
        cwrite(4'd1, 32'h0, 4'hF);
        creq(40'h00_0000_1234, 1'b1, 1'b0, 2'd0, "R6 io disabled");
        cwrite(4'd1, 32'h1, 4'hF);
        creq(40'h00_0000_12FF, 1'b1, 1'b1, 2'd1, "R6 io hit");
        creq(40'hFF_FE00_1234, 1'b1, 1'b1, 2'd1, "R6 upper bits ignored");
        creq(40'h00_0000_1300, 1'b1, 1'b0, 2'd0, "R6 io miss");
        creq(40'h00_8000_0000, 1'b0, 1'b0, 2'd0, "R9 mem disabled");
        cwrite(4'd1, 32'h3, 4'hF);
        creq(40'h00_8000_0FFF, 1'b0, 1'b1, 2'd2, "R7 mem32 hit");
        creq(40'h01_8000_0000, 1'b0, 1'b0, 2'd0, "R7 above 4G");
        creq(40'h5A_0010_0040, 1'b0, 1'b1, 2'd3, "R8 mem64 hit");
        creq(40'h5A_0020_0000, 1'b0, 1'b0, 2'd0, "R8 mem64 miss");
        creq(40'h5A_0010_0040, 1'b1, 1'b0, 2'd0, "R6 io flag skips memory");
        // Overlapping memory windows
        cwrite(4'd7, 32'h0, 4'hF);
        cwrite(4'd6, 32'h8000_0000, 4'hF);
        creq(40'h00_8000_0010, 1'b0, 1'b1, 2'd2, "R9 mem32 priority");
        creq(40'h00_8000_1000, 1'b0, 1'b1, 2'd3, "R9 mem64 only");
        // Idle cycle: no request
        @(posedge clk); #1 req_addr = 40'h00_8000_0010; req_is_io = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R10 no valid", 64'({req_hit, req_win}), 64'h0);
        // Capabilities pointer and interrupt bytes
        cwrite(4'd13, 32'hFFFF_FFFF, 4'hF);
        cread(4'd13, 32'h0000_0040, "R11 cap");
        cwrite(4'd15, 32'hFFFF_FFFF, 4'hF);
        cread(4'd15, 32'h0000_00FF, "R12 full");
        cwrite(4'd15, 32'h0000_005A, 4'b0001);
        cread(4'd15, 32'h0000_005A, "R12 scratch");
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule